// File: doc/BRIEF.md
# Power-Line Command Frame Receiver

This block rebuilds a home-control command frame from a power-line carrier modem. The modem gives two signals. The first is a receive line that falls once in every half-cycle of the mains that carried a carrier burst. The second is a square wave that toggles at each mains zero crossing. The receiver does not sample every half-cycle. It acts only at each falling receive edge. At that edge it compares the zero-crossing level with a phase it stored earlier. From this it works out whether the burst fell in the true or the complement half-cycle of a bit, and so recovers each data bit.

A frame has three parts. The first is a start code of three bursts followed by a silent half-cycle. The receiver infers that silent half-cycle and never observes it. Next come nine data bits, each sent in true form and then in complemented form. The first four bits form the house pattern and the last five form the key pattern. A complete frame spans 22 half-cycles. Each pattern is mapped back to its number, and the block offers the result as a packet with three fields: flags, a 4-bit house number and a 5-bit key number. Edges that fall outside their expected slot time produce an error packet. A frame that stalls, so that a watchdog expires, also produces an error packet. The flags also record whether a local transmission was under way when the frame began.

The packet leaves on a valid/ready interface. Once `pkt_valid` is high, it and all packet fields stay unchanged until a cycle in which `pkt_ready` is also high. The downstream side may hold `pkt_ready` low for as long as it needs. If a new packet is produced while the held one is still refused, the new packet is dropped and a sticky overrun flag is set. In the same cycle as an acceptance, a newly produced packet replaces the old one.

Top module: `plc_frame_rx`

## Requirements
- R1: After reset, `pkt_valid` and `overrun` are 0. While idle, a falling edge of `rx_n` starts a frame. At that edge the block stores the synchronised `zc` level, latches `local_tx`, and starts its slot and watchdog timing.
- R2: The second edge and the third edge must each arrive in the next half-cycle, so that `zc` differs from the stored level at that edge. Each must also arrive within the timing window. Otherwise the frame is abandoned with no packet, and the block is idle again.
- R3: After the third start edge, the block treats the fourth half-cycle as a silent 0. Each later edge yields one data bit: 1 if `zc` differs from the stored level, 0 if it equals it. The stored level is the one taken at the second edge. Bits are shifted in first-received-first. Nine bits complete a frame of 22 half-cycles.
- R4: The first four received bits form the house pattern p. `pkt_house` is looked up from p in this order: for p = 0..15 the values are 12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9.
- R5: The last five received bits form the key pattern q. If q is odd, `pkt_key` = 16 + (q>>1). If q is even, `pkt_key` is the R4 lookup of q>>1.
- R6: `pkt_flags[0]` is the `local_tx` value latched at frame start. `pkt_flags[1]` is 1 for an error packet. An error packet carries `pkt_house` = 0 and `pkt_key` = 0.
- R7: An edge is late or early if it lies more than HALF_CYC/3 cycles from its expected slot time. For a data edge, the expected slot is the true slot if `zc` differs from the stored level and the complement slot if it equals it. Such an edge ends the frame at once with an error packet.
- R8: If a frame is not complete WDOG_HALVES*HALF_CYC cycles after its first edge, the block emits an error packet and returns to idle.
- R9: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid` and all packet fields hold. After an accepting cycle with no new packet, `pkt_valid` is 0.
- R10: A packet produced while `pkt_valid` is 1 and `pkt_ready` is 0 is dropped. The held packet is kept, and `overrun` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_n | input | 1 | Modem receive line, falls once per burst half-cycle (asynchronous) |
| zc | input | 1 | Zero-crossing square wave (asynchronous) |
| local_tx | input | 1 | High while a local transmission is active |
| pkt_ready | input | 1 | Downstream accepts the packet |
| pkt_valid | output | 1 | Packet available |
| pkt_flags | output | 2 | Bit 0 local, bit 1 error |
| pkt_house | output | 4 | Decoded house number |
| pkt_key | output | 5 | Decoded key number |
| overrun | output | 1 | Sticky: a packet was dropped |

## Verification
The bench drives well-timed frames with random 9-bit payloads and random local state. It also sweeps all sixteen house patterns, with both odd and even key patterns, so that every lookup entry and both branches of the key rule are checked. Three broken-frame cases each test one abort path. A second start burst that repeats the first half-cycle's phase must end the frame silently. A data burst shifted by half a slot must produce an immediate error packet. A frame that stops after one data bit must produce an error packet only when the watchdog expires. Two frames back to back with the output refused show that the packet is held and dropped correctly.

// File: rtl/plc_rx_pkg.sv
package plc_rx_pkg;
  localparam int HOUSE_W   = 4;
  localparam int KEY_W     = 5;
  localparam int FLAG_W    = 2;
  localparam int PAYLOAD_W = HOUSE_W + KEY_W;
  localparam int CNT_W     = 5;
  localparam int LAST_HALF = 22;
  localparam int FLG_LOCAL = 0;
  localparam int FLG_ERR   = 1;

  typedef struct packed {
    logic [FLAG_W-1:0]  flags;
    logic [HOUSE_W-1:0] house;
    logic [KEY_W-1:0]   key;
  } plc_pkt_t;

  // Pattern to house number.
  function automatic logic [HOUSE_W-1:0] house_of(input logic [HOUSE_W-1:0] pat);
    logic [HOUSE_W-1:0] n;
    case (pat)
      4'd0:  n = 4'd12;
      4'd1:  n = 4'd4;
      4'd2:  n = 4'd2;
      4'd3:  n = 4'd10;
      4'd4:  n = 4'd14;
      4'd5:  n = 4'd6;
      4'd6:  n = 4'd0;
      4'd7:  n = 4'd8;
      4'd8:  n = 4'd13;
      4'd9:  n = 4'd5;
      4'd10: n = 4'd3;
      4'd11: n = 4'd11;
      4'd12: n = 4'd15;
      4'd13: n = 4'd7;
      4'd14: n = 4'd1;
      default: n = 4'd9;
    endcase
    return n;
  endfunction

  // Key pattern to key number: odd patterns are the function codes.
  function automatic logic [KEY_W-1:0] key_of(input logic [KEY_W-1:0] pat);
    if (pat[0]) return {1'b1, pat[KEY_W-1:1]};
    else        return {1'b0, house_of(pat[KEY_W-1:1])};
  endfunction
endpackage

// File: rtl/plc_rx_sync.sv
module plc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_n_raw,
  input  logic zc_raw,
  output logic rx_fall,
  output logic zc_s
);
  localparam int NSIG = 2;
  localparam logic [NSIG-1:0] RST_VAL = 2'b01; // rx idles high, zc low

  logic [NSIG-1:0] stage [STAGES];
  logic            rx_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= {zc_raw, rx_n_raw};
        else             stage[s] <= stage[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= stage[STAGES-1][0];
  end

  assign rx_fall = rx_prev & ~stage[STAGES-1][0];
  assign zc_s    = stage[STAGES-1][1];
endmodule

// File: rtl/plc_rx_timer.sv
module plc_rx_timer
  import plc_rx_pkg::*;
#(
  parameter int HALF_CYC = 64,
  parameter int TOL_CYC  = 21,
  parameter int WDOG_CYC = 1920
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] slot_a,
  input  logic [CNT_W-1:0] slot_b,
  output logic             ok_a,
  output logic             ok_b,
  output logic             expired
);
  localparam int EW = $clog2(WDOG_CYC + 1);
  localparam logic [EW-1:0] LIMIT = EW'(WDOG_CYC);

  logic [EW-1:0]    elapsed;
  logic [CNT_W-1:0] slots [2];
  logic [1:0]       ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        elapsed <= '0;
    else if (start)                    elapsed <= EW'(1);
    else if (run && elapsed != LIMIT)  elapsed <= elapsed + 1'b1;
  end

  assign expired  = run && (elapsed == LIMIT);
  assign slots[0] = slot_a;
  assign slots[1] = slot_b;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_win
      int e_v, x_v;
      always_comb begin
        e_v   = int'(elapsed);
        x_v   = int'(slots[g]) * HALF_CYC;
        ok[g] = (e_v + TOL_CYC >= x_v) && (e_v <= x_v + TOL_CYC);
      end
    end
  endgenerate

  assign ok_a = ok[0];
  assign ok_b = ok[1];
endmodule

// File: rtl/plc_rx_decoder.sv
module plc_rx_decoder
  import plc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_fall,
  input  logic             zc_s,
  input  logic             local_tx,
  input  logic             ok_a,
  input  logic             ok_b,
  input  logic             expired,
  output logic             active,
  output logic             start,
  output logic [CNT_W-1:0] slot_a,
  output logic [CNT_W-1:0] slot_b,
  output logic             emit,
  output plc_pkt_t         emit_pkt
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(LAST_HALF - 2);

  logic [CNT_W-1:0]     rcount;
  logic                 rphase;
  logic                 local_q;
  logic [PAYLOAD_W-1:0] bits;
  logic                 zc_diff, data_ok;
  logic [PAYLOAD_W-1:0] new_bits;
  plc_pkt_t             err_pkt, good_pkt;

  assign zc_diff  = zc_s ^ rphase;
  assign data_ok  = zc_diff ? ok_a : ok_b;
  assign new_bits = {bits[PAYLOAD_W-2:0], zc_diff};
  assign slot_a   = rcount;
  assign slot_b   = rcount + 1'b1;
  assign start    = edge_fall && !active;

  always_comb begin
    err_pkt        = '0;
    err_pkt.flags  = {1'b1, local_q};
    good_pkt.flags = {1'b0, local_q};
    good_pkt.house = house_of(new_bits[PAYLOAD_W-1:KEY_W]);
    good_pkt.key   = key_of(new_bits[KEY_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      rcount   <= '0;
      rphase   <= 1'b0;
      local_q  <= 1'b0;
      bits     <= '0;
      emit     <= 1'b0;
      emit_pkt <= '0;
    end else begin
      emit <= 1'b0;
      if (!active) begin
        if (edge_fall) begin
          active  <= 1'b1;
          rcount  <= CNT_W'(1);
          rphase  <= zc_s;
          local_q <= local_tx;
          bits    <= '0;
        end
      end else if (expired) begin
        active   <= 1'b0;
        emit     <= 1'b1;
        emit_pkt <= err_pkt;
      end else if (edge_fall) begin
        if (rcount < CNT_W'(4)) begin
          // start code: each burst must sit in the next half-cycle
          if (ok_a && zc_diff) begin
            if (rcount == CNT_W'(2)) begin
              rcount <= CNT_W'(4); // silent fourth half-cycle inferred
            end else begin
              rcount <= rcount + 1'b1;
              rphase <= zc_s;
            end
          end else begin
            active <= 1'b0;        // invalid start, no packet
          end
        end else if (!data_ok) begin
          active   <= 1'b0;
          emit     <= 1'b1;
          emit_pkt <= err_pkt;
        end else begin
          bits   <= new_bits;
          rcount <= rcount + CNT_W'(2);
          if (rcount == LAST_DATA) begin
            active   <= 1'b0;
            emit     <= 1'b1;
            emit_pkt <= good_pkt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/plc_rx_outbuf.sv
module plc_rx_outbuf
  import plc_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     emit,
  input  plc_pkt_t emit_pkt,
  input  logic     pkt_ready,
  output logic     pkt_valid,
  output plc_pkt_t pkt,
  output logic     overrun
);
  logic blocked;
  assign blocked = pkt_valid && !pkt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt       <= '0;
      overrun   <= 1'b0;
    end else if (emit) begin
      if (blocked) begin
        overrun <= 1'b1;
      end else begin
        pkt_valid <= 1'b1;
        pkt       <= emit_pkt;
      end
    end else if (pkt_valid && pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/plc_frame_rx.sv
module plc_frame_rx
  import plc_rx_pkg::*;
#(
  parameter int HALF_CYC    = 64,
  parameter int WDOG_HALVES = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_n,
  input  logic               zc,
  input  logic               local_tx,
  input  logic               pkt_ready,
  output logic               pkt_valid,
  output logic [FLAG_W-1:0]  pkt_flags,
  output logic [HOUSE_W-1:0] pkt_house,
  output logic [KEY_W-1:0]   pkt_key,
  output logic               overrun
);
  localparam int TOL_CYC  = HALF_CYC / 3;
  localparam int WDOG_CYC = HALF_CYC * WDOG_HALVES;

  logic             rx_fall, zc_s;
  logic             ok_a, ok_b, expired, active, start, emit;
  logic [CNT_W-1:0] slot_a, slot_b;
  plc_pkt_t         emit_pkt, held;

  plc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_n_raw(rx_n), .zc_raw(zc),
    .rx_fall(rx_fall), .zc_s(zc_s)
  );

  plc_rx_timer #(.HALF_CYC(HALF_CYC), .TOL_CYC(TOL_CYC), .WDOG_CYC(WDOG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(active),
    .slot_a(slot_a), .slot_b(slot_b), .ok_a(ok_a), .ok_b(ok_b), .expired(expired)
  );

  plc_rx_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .edge_fall(rx_fall), .zc_s(zc_s), .local_tx(local_tx),
    .ok_a(ok_a), .ok_b(ok_b), .expired(expired), .active(active), .start(start),
    .slot_a(slot_a), .slot_b(slot_b), .emit(emit), .emit_pkt(emit_pkt)
  );

  plc_rx_outbuf u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .emit_pkt(emit_pkt), .pkt_ready(pkt_ready),
    .pkt_valid(pkt_valid), .pkt(held), .overrun(overrun)
  );

  assign pkt_flags = held.flags;
  assign pkt_house = held.house;
  assign pkt_key   = held.key;
endmodule

// File: rtl/plc_frame_rx_chk.sv
module plc_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_ready,
  input logic       pkt_valid,
  input logic [1:0] pkt_flags,
  input logic [3:0] pkt_house,
  input logic [4:0] pkt_key,
  input logic       overrun
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_flags) && $stable(pkt_house) && $stable(pkt_key)); // R9

  AST_ERR_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_flags[1] |-> pkt_house == 4'd0 && pkt_key == 5'd0); // R6

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(pkt_valid && !pkt_ready)); // R10
endmodule

bind plc_frame_rx plc_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
  .pkt_flags(pkt_flags), .pkt_house(pkt_house), .pkt_key(pkt_key), .overrun(overrun)
);

// File: tb/sim_plc_frame_rx.sv
module sim_plc_frame_rx;
  localparam int HALF = 64;
  localparam int WDOG = HALF * 30;
  localparam int Q    = 8;
  localparam int PW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_n = 1'b1, zc = 1'b0, local_tx = 1'b0, pkt_ready = 1'b0;
  logic pkt_valid, overrun;
  logic [1:0] pkt_flags;
  logic [3:0] pkt_house;
  logic [4:0] pkt_key;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plc_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_n(rx_n), .zc(zc), .local_tx(local_tx),
    .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_flags(pkt_flags),
    .pkt_house(pkt_house), .pkt_key(pkt_key), .overrun(overrun)
  );

  function automatic int exp_house(input logic [3:0] p);
    int t [16] = '{12, 4, 2, 10, 14, 6, 0, 8, 13, 5, 3, 11, 15, 7, 1, 9};
    return t[p];
  endfunction

  function automatic int exp_key(input logic [4:0] p);
    return p[0] ? 16 + int'(p[4:1]) : exp_house(p[4:1]);
  endfunction

  function automatic logic [21:0] frame_mask(input logic [8:0] b);
    logic [21:0] m = 22'b111;
    for (int k = 0; k < 9; k++) m[b[8-k] ? 4 + 2*k : 5 + 2*k] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_mask(input logic [21:0] m, input int late_slot);
    for (int i = 0; i < 22; i++) begin
      int at = Q + ((i == late_slot) ? HALF / 2 : 0);
      for (int c = 0; c < HALF; c++) begin
        @(negedge clk);
        if (c == 0) zc = ~zc;
        if (m[i] && c == at) rx_n = 1'b0;
        if (m[i] && c == at + PW) rx_n = 1'b1;
      end
    end
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = 1'b0;
    for (int c = 0; c < lim && !got; c++) begin
      @(negedge clk);
      got = pkt_valid;
    end
  endtask

  task automatic accept();
    @(negedge clk) pkt_ready = 1'b1;
    @(negedge clk) pkt_ready = 1'b0;
  endtask

  task automatic expect_pkt(input int fl, input int h, input int k, input string tag);
    bit got;
    wait_valid(3000, got);
    chk(got, {tag, " valid"}, int'(got), 1);
    chk(int'(pkt_flags) == fl, {tag, " flags"}, int'(pkt_flags), fl);
    chk(int'(pkt_house) == h, {tag, " house"}, int'(pkt_house), h);
    chk(int'(pkt_key) == k, {tag, " key"}, int'(pkt_key), k);
    accept();
    chk(!pkt_valid, "R9 valid cleared after accept", int'(pkt_valid), 0);
  endtask

  task automatic good_frame(input logic [8:0] b, input bit loc, input string tag);
    local_tx = loc;
    send_mask(frame_mask(b), -1);
    expect_pkt(int'(loc), exp_house(b[8:5]), exp_key(b[4:0]), tag);
    local_tx = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit got;
    int unsigned seed = $urandom(32'h2f1c);
    seed = seed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pkt_valid, "R1 reset valid", int'(pkt_valid), 0);
    chk(!overrun, "R1 reset overrun", int'(overrun), 0);

    // R3 directed payloads
    good_frame(9'h000, 1'b0, "R3 all zero");
    good_frame(9'h1ff, 1'b1, "R3 all one R6 local");
    good_frame(9'h155, 1'b0, "R3 alternating");

    // R4 R5 sweep of all house patterns, odd and even keys
    for (int h = 0; h < 16; h++)
      good_frame({4'(h), 5'((h * 7 + h) % 32) ^ 5'(h & 1)}, 1'(h >> 3), "R4 R5 sweep");

    // random payloads
    for (int n = 0; n < 10; n++)
      good_frame(9'($urandom), 1'($urandom), "R3 random");

    // R2 second burst repeats first phase
    send_mask(22'b101, -1);
    wait_valid(WDOG + 200, got);
    chk(!got, "R2 bad second start edge", int'(got), 0);
    // R2 third burst repeats second phase
    send_mask(22'b1011, -1);
    wait_valid(WDOG + 200, got);
    chk(!got, "R2 bad third start edge", int'(got), 0);

    // R7 data burst half a slot late, frame stops there
    local_tx = 1'b1;
    send_mask(frame_mask(9'h1ff) & 22'h7f, 6);
    local_tx = 1'b0;
    expect_pkt(3, 0, 0, "R7 late edge");
    wait_valid(WDOG + 200, got);
    chk(!got, "R7 no extra packet", int'(got), 0);

    // R8 frame stalls after one data bit
    send_mask(22'b10111, -1);
    repeat (WDOG - 22 * HALF - 100) @(negedge clk);
    chk(!pkt_valid, "R8 no packet before watchdog", int'(pkt_valid), 0);
    expect_pkt(2, 0, 0, "R8 watchdog");

    // R10 overrun: two frames with output refused
    send_mask(frame_mask(9'h0a3), -1);
    local_tx = 1'b1;
    send_mask(frame_mask(9'h13c), -1);
    local_tx = 1'b0;
    repeat (50) @(negedge clk);
    chk(overrun, "R10 overrun set", int'(overrun), 1);
    chk(pkt_valid && pkt_flags == 2'd0, "R10 first packet held", int'(pkt_flags), 0);
    chk(int'(pkt_house) == exp_house(4'h5), "R9 R10 held house", int'(pkt_house), exp_house(4'h5));
    chk(int'(pkt_key) == exp_key(5'h03), "R9 R10 held key", int'(pkt_key), exp_key(5'h03));
    accept();
    chk(!pkt_valid, "R10 dropped packet absent", int'(pkt_valid), 0);
    chk(overrun, "R10 overrun sticky", int'(overrun), 1);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule